// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between a node's transmit data input and the dominant-drive enable of a single-wire, open-drain serial bus. A low level on the transmit input asks for the dominant bus level. The block passes that request to the driver after synchronising it. It also times how long the request has lasted without a break. If the request runs too long, the block releases the bus to the recessive level and raises a latched timeout flag. The flag stays set until the input has been held recessive for a qualified minimum interval.

Thermal-fault and sleep indications override every other path and keep the driver off. When either indication ends while the input is still low, the driver stays off until the input has been seen high. This keeps the block from re-asserting the bus in the middle of a frame. An unconnected input reads as low, so a floating pin gets the same timeout treatment as a stuck transmitter. Both time limits are cycle counts taken from a clock-frequency parameter. Counts below are in samples of the synchronised input. DOM_CYC = CLK_KHZ*DOM_TIMEOUT_US/1000 and REC_CYC = CLK_KHZ*REC_QUAL_US/1000.

Top module: `txd_dom_guard`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, drv_dom_o and timeout_o are 0. Both counters are cleared and no fault is held.
- R2: txd_i = 0 requests dominant and txd_i = 1 requests recessive. With no fault, gating or re-arm pending, drv_dom_o = 1 exactly for the low samples, 3 clock edges after txd_i changes, since there are two synchroniser stages and one output register.
- R3: drv_dom_o stays 1 for at most DOM_CYC consecutive low samples. On low sample DOM_CYC+1, drv_dom_o returns to 0 and timeout_o rises in the same cycle. The dominant counter saturates and does not wrap.
- R4: A single high sample before the limit clears the dominant count. Low runs of DOM_CYC or fewer samples, separated by one high sample, never trip the timeout.
- R5: Once timeout_o is 1, drv_dom_o stays 0. timeout_o clears on high sample REC_CYC+1 of an unbroken high run, and the next low sample drives again.
- R6: A low sample during recovery restarts the recovery qualification from zero.
- R7: While thermal_i (synchronised) is 1, drv_dom_o is 0.
- R8: While sleep_i (synchronised) is 1, drv_dom_o is 0.
- R9: After thermal or sleep gating ends, drv_dom_o stays 0 until txd_i has been sampled high at least once.
- R10: The dominant timer keeps running during gating, so a request held low through gating still trips timeout_o.
- R11: A txd_i held low from reset onwards (floating pin) drives for DOM_CYC samples and then trips timeout_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_i | input | 1 | Synchronous reset, active high |
| txd_i | input | 1 | Transmit data, low requests dominant |
| thermal_i | input | 1 | Thermal-fault indication, blocks driving |
| sleep_i | input | 1 | Sleep indication, blocks driving |
| drv_dom_o | output | 1 | Driver enable for the dominant level |
| timeout_o | output | 1 | Latched dominant-timeout status |

## Verification
A dominant counter that is wrong shows up as a dominant pulse of the wrong length on drv_dom_o. The error is visible at the ports three edges after the last low input, and a sweep of low-run lengths around DOM_CYC exposes it. A recovery counter or fault latch that is wrong shows up in timeout_o and in whether a short low pulse after a high run of a given length reaches the driver. A lost re-arm flag or gating path lets drv_dom_o rise during or just after a blocked interval. That error shows in the first low sample after gating ends.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;

    typedef struct packed {
        logic drv;
        logic fault;
        logic armed;
    } guard_state_t;

    // Cycles for a duration in microseconds at a clock given in kHz, at least one.
    function automatic int unsigned us_to_cycles(input int unsigned clk_khz,
                                                 input int unsigned dur_us);
        logic [63:0] prod;
        logic [63:0] cyc;
        prod = 64'(clk_khz) * 64'(dur_us);
        cyc  = prod / 64'd1000;
        if (cyc == 64'd0) begin
            cyc = 64'd1;
        end
        return 32'(cyc);
    endfunction

endpackage

// File: rtl/txd_guard_sync.sv
module txd_guard_sync #(
    parameter int unsigned WIDTH = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/txd_guard_counter.sv
module txd_guard_counter #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic inc_i,
    output logic full_o
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != LIM)) begin
            cnt_d = cnt_q + 1'b1;   // saturates at LIM
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign full_o = (cnt_q == LIM);
endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
    parameter int unsigned CLK_KHZ        = 50000,
    parameter int unsigned DOM_TIMEOUT_US = 18400,
    parameter int unsigned REC_QUAL_US    = 10
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic txd_i,
    input  logic thermal_i,
    input  logic sleep_i,
    output logic drv_dom_o,
    output logic timeout_o
);
    import txd_guard_pkg::*;

    localparam int unsigned DOM_CYC = us_to_cycles(CLK_KHZ, DOM_TIMEOUT_US);
    localparam int unsigned REC_CYC = us_to_cycles(CLK_KHZ, REC_QUAL_US);

    logic [2:0] raw_w;
    logic [2:0] sync_w;
    logic       txd_s;
    logic       block_s;
    logic       dom_full;
    logic       rec_full;
    logic       rec_clr;

    guard_state_t st_d;
    guard_state_t st_q;

    // Synchronised copies reset to recessive and ungated.
    assign raw_w = {sleep_i, thermal_i, txd_i};

    txd_guard_sync #(
        .WIDTH  (3),
        .RST_VAL(3'b001)
    ) sync_i (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .d_i  (raw_w),
        .q_o  (sync_w)
    );

    assign txd_s   = sync_w[0];
    assign block_s = sync_w[1] | sync_w[2];

    // Counts consecutive low samples, independent of gating.
    txd_guard_counter #(
        .LIMIT(DOM_CYC)
    ) dom_cnt_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (txd_s),
        .inc_i (!txd_s),
        .full_o(dom_full)
    );

    // Counts consecutive high samples while the fault is held.
    assign rec_clr = !st_q.fault || !txd_s || rec_full;

    txd_guard_counter #(
        .LIMIT(REC_CYC)
    ) rec_cnt_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (rec_clr),
        .inc_i (1'b1),
        .full_o(rec_full)
    );

    always_comb begin
        st_d = st_q;

        if (!st_q.fault && !txd_s && dom_full) begin
            st_d.fault = 1'b1;
        end else if (st_q.fault && txd_s && rec_full) begin
            st_d.fault = 1'b0;
        end

        if (block_s) begin
            st_d.armed = 1'b0;
        end else if (txd_s) begin
            st_d.armed = 1'b1;
        end

        st_d.drv = !txd_s && st_q.armed && !block_s && !st_d.fault;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{drv: 1'b0, fault: 1'b0, armed: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_dom_o = st_q.drv;
    assign timeout_o = st_q.fault;
endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
    parameter int unsigned DOM_CYC = 4
) (
    input logic clk_i,
    input logic rst_i,
    input logic drv_dom_o,
    input logic timeout_o,
    input logic txd_s,
    input logic block_s,
    input logic dom_full
);
    localparam int unsigned RW = $clog2(DOM_CYC + 2);
    localparam logic [RW-1:0] RMAX = RW'(DOM_CYC + 1);
    localparam logic [RW-1:0] RLIM = RW'(DOM_CYC);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (!drv_dom_o) begin
            run_q <= '0;
        end else if (run_q != RMAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!drv_dom_o && !timeout_o));

    assert_drive_needs_low_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_dom_o |-> $past(!txd_s));

    assert_dom_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_q == RLIM) |-> !drv_dom_o);

    assert_trip_after_full_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(timeout_o) |-> $past(dom_full && !txd_s));

    assert_no_drive_in_fault_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        drv_dom_o |-> !timeout_o);

    assert_clear_on_high_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(timeout_o) |-> $past(txd_s));

    // Covers R7 and R8: either indication blocks the next output.
    assert_block_gate_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        block_s |=> !drv_dom_o);
endmodule

bind txd_dom_guard txd_dom_guard_chk #(.DOM_CYC(DOM_CYC)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .drv_dom_o(drv_dom_o),
    .timeout_o(timeout_o),
    .txd_s    (txd_s),
    .block_s  (block_s),
    .dom_full (dom_full)
);

// File: tb/txd_dom_guard_tb_top.sv
module txd_dom_guard_tb_top;
    localparam int unsigned CLK_KHZ = 1000;
    localparam int unsigned DOM_US  = 40;
    localparam int unsigned REC_US  = 12;
    localparam int DOM = int'(CLK_KHZ * DOM_US / 1000);
    localparam int REC = int'(CLK_KHZ * REC_US / 1000);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic txd = 1'b1;
    logic therm = 1'b0;
    logic slp = 1'b0;
    logic drv_dom_o;
    logic timeout_o;

    int checks = 0;
    int errors = 0;
    int hi_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txd_dom_guard #(
        .CLK_KHZ       (CLK_KHZ),
        .DOM_TIMEOUT_US(DOM_US),
        .REC_QUAL_US   (REC_US)
    ) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .txd_i    (txd),
        .thermal_i(therm),
        .sleep_i  (slp),
        .drv_dom_o(drv_dom_o),
        .timeout_o(timeout_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic t, input logic th, input logic sl);
        @(negedge clk);
        if (drv_dom_o) hi_cnt++;
        txd = t;
        therm = th;
        slp = sl;
    endtask

    task automatic run(input int n, input logic t, input logic th, input logic sl);
        for (int i = 0; i < n; i++) tick(t, th, sl);
    endtask

    task automatic do_reset(input logic t);
        @(negedge clk);
        rst = 1'b1;
        txd = t;
        therm = 1'b0;
        slp = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 drv in reset", int'(drv_dom_o), 0);
        chk("R1 timeout in reset", int'(timeout_o), 0);
        rst = 1'b0;
        hi_cnt = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R2, R3: sweep of low-run lengths around the limit.
        for (int len = 1; len <= DOM + 4; len++) begin
            do_reset(1'b1);
            run(len, 1'b0, 1'b0, 1'b0);
            run(8, 1'b1, 1'b0, 1'b0);
            chk("R2 R3 dominant cycles", hi_cnt, (len > DOM) ? DOM : len);
            chk("R3 timeout flag", int'(timeout_o), (len > DOM) ? 1 : 0);
        end

        // R4: long request broken by single high samples never trips.
        do_reset(1'b1);
        for (int k = 0; k < 10; k++) begin
            run(DOM, 1'b0, 1'b0, 1'b0);
            run(1, 1'b1, 1'b0, 1'b0);
        end
        run(6, 1'b1, 1'b0, 1'b0);
        chk("R4 dominant cycles", hi_cnt, 10 * DOM);
        chk("R4 no timeout", int'(timeout_o), 0);

        // R5: sweep of recovery high-run lengths.
        for (int h = 1; h <= REC + 4; h++) begin
            do_reset(1'b1);
            run(DOM + 3, 1'b0, 1'b0, 1'b0);
            run(h, 1'b1, 1'b0, 1'b0);
            run(3, 1'b0, 1'b0, 1'b0);
            run(8, 1'b1, 1'b0, 1'b0);
            chk("R5 dominant cycles", hi_cnt, DOM + ((h > REC) ? 3 : 0));
            chk("R5 timeout after recovery", int'(timeout_o), (h > REC) ? 0 : 1);
        end

        // R6: a low sample restarts the qualification.
        do_reset(1'b1);
        run(DOM + 3, 1'b0, 1'b0, 1'b0);
        run(REC, 1'b1, 1'b0, 1'b0);
        run(1, 1'b0, 1'b0, 1'b0);
        run(REC, 1'b1, 1'b0, 1'b0);
        hi_cnt = 0;
        run(5, 1'b0, 1'b0, 1'b0);
        run(4, 1'b1, 1'b0, 1'b0);
        chk("R6 still locked", hi_cnt, 0);
        chk("R6 timeout held", int'(timeout_o), 1);
        run(REC + 1, 1'b1, 1'b0, 1'b0);
        hi_cnt = 0;
        run(5, 1'b0, 1'b0, 1'b0);
        run(6, 1'b1, 1'b0, 1'b0);
        chk("R6 drive after full run", hi_cnt, 5);
        chk("R6 timeout cleared", int'(timeout_o), 0);

        // R7: thermal gating.
        do_reset(1'b1);
        run(10, 1'b0, 1'b1, 1'b0);
        run(6, 1'b1, 1'b1, 1'b0);
        chk("R7 no drive under thermal", hi_cnt, 0);

        // R8: sleep gating.
        do_reset(1'b1);
        run(10, 1'b0, 1'b0, 1'b1);
        run(6, 1'b1, 1'b0, 1'b1);
        chk("R8 no drive in sleep", hi_cnt, 0);

        // R9: re-arm after gating released while low.
        do_reset(1'b1);
        run(5, 1'b0, 1'b1, 1'b0);
        run(10, 1'b0, 1'b0, 1'b0);
        run(2, 1'b1, 1'b0, 1'b0);
        chk("R9 no drive before high seen", hi_cnt, 0);
        hi_cnt = 0;
        run(6, 1'b0, 1'b0, 1'b0);
        run(6, 1'b1, 1'b0, 1'b0);
        chk("R9 drive after re-arm", hi_cnt, 6);

        // R9: sleep pulse mid-frame ends the drive for that frame.
        do_reset(1'b1);
        run(5, 1'b0, 1'b0, 1'b0);
        run(3, 1'b0, 1'b0, 1'b1);
        run(5, 1'b0, 1'b0, 1'b0);
        run(6, 1'b1, 1'b0, 1'b0);
        chk("R9 mid-frame gating", hi_cnt, 5);

        // R10: timer runs under gating.
        do_reset(1'b1);
        run(DOM + 5, 1'b0, 1'b1, 1'b0);
        run(3, 1'b1, 1'b1, 1'b0);
        chk("R10 timeout under gating", int'(timeout_o), 1);
        run(4, 1'b0, 1'b0, 1'b0);
        run(4, 1'b1, 1'b0, 1'b0);
        chk("R10 no drive while locked", hi_cnt, 0);

        // R11: input low from reset onwards.
        do_reset(1'b0);
        run(DOM + 6, 1'b0, 1'b0, 1'b0);
        run(8, 1'b1, 1'b0, 1'b0);
        chk("R11 floating dominant cycles", hi_cnt, DOM);
        chk("R11 floating timeout", int'(timeout_o), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule